// File: doc/BRIEF.md
# Vector Register Gather Unit

The unit runs one register-gather permute over a 32-entry vector register file model that it owns. Each destination element is loaded with the source-vector element chosen by an index. The index comes from one of three places, selected by the instruction form: the matching element of an index vector register, a scalar operand that applies to every element, or a 5-bit unsigned immediate that applies to every element. Element width is chosen per operation from 8, 16, 32 or 64 bits. Register grouping is fixed at one register, so VLMAX is VLEN divided by the element width.

After a `start_i` pulse, the unit accepts the instruction word, the element width, the vector length and the scalar operand. It walks the elements one per clock into a private result buffer, including the tail positions. It then commits the buffer to the destination register in one write and pulses `done_o`. An illegal request completes at once with `illegal_o` and leaves the register file untouched. A side port loads and inspects registers while the unit is idle.

Top module: `vgather_unit`

## Requirements
- R1: An instruction is accepted only with opcode bits[6:0]=1010111 and funct6 bits[31:26]=001100. The form comes from bits[14:12]: 000 is index-vector, 100 is scalar index, 011 is immediate index. Any other encoding is flagged illegal. The destination is bits[11:7], the index register or immediate is bits[19:15], the source register is bits[24:20], and bit 25 is vm.
- R2: In index-vector form, element i of the destination receives the source element at the position held in element i of the index register. The index is read as an unsigned number at the current element width. `sew_i` codes 0, 1, 2 and 3 select 8, 16, 32 and 64 bits.
- R3: In scalar form, all 64 bits of `scalar_i` are taken as one unsigned index for every element.
- R4: In immediate form, bits[19:15] are taken as one unsigned index for every element.
- R5: An index equal to or above VLMAX (VLEN/element width) writes zero to the destination element.
- R6: When vm is 0 and bit i*width of register 0 is clear, destination element i keeps its previous value.
- R7: With vl nonzero, destination elements from vl up to VLMAX-1 become zero.
- R8: With vl equal to 0 and a legal instruction, no register changes. `done_o` pulses in the cycle after acceptance and `illegal_o` stays low.
- R9: A request is illegal in each of these cases:
  - the destination equals the source register;
  - in index-vector form, the destination equals the index register;
  - vm is 0 and the destination is register 0;
  - vl exceeds VLMAX.

  For an illegal request, `illegal_o` and `done_o` pulse together in the cycle after acceptance, and no register changes.
- R10: A legal run with nonzero vl keeps `busy_o` high from the acceptance edge. `done_o` goes high for one cycle after the (VLMAX+2)-th rising edge, counting the acceptance edge as the first. At that point the destination register holds the result.
- R11: While `busy_o` is high, `start_i` is ignored. The running operation completes unchanged and produces exactly one `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to run the instruction on the inputs |
| insn_i | input | 32 | Instruction word |
| sew_i | input | 2 | Element width code |
| vl_i | input | VLW (5) | Vector length |
| scalar_i | input | 64 | Scalar index operand |
| rf_we_i | input | 1 | Side-port register write (taken only when idle) |
| rf_waddr_i | input | 5 | Side-port write register |
| rf_wdata_i | input | VLEN (128) | Side-port write data |
| rf_raddr_i | input | 5 | Side-port read register |
| rf_rdata_o | output | VLEN (128) | Side-port read data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | One-cycle illegal-request pulse, alongside done_o |

## Verification
The hardest situation to reach is a run in which all of these happen in one operation:
- masked-off elements keep their old data;
- out-of-range indices produce zeros;
- the tail is cleared.

The old destination data is only visible after commit, so a wrong merge order shows up as a value mismatch and nothing else. The stimulus preloads the destination registers with distinctive filler and gives register 0 a mixed bit pattern. It uses index vectors that mix in-range values, values just over VLMAX and values whose upper bytes are set. It also uses a scalar index that is out of range only through its upper bits. A second start is driven into the middle of a long run to show that it has no effect on the result or on the completion count.

// File: rtl/gather_pkg.sv
package gather_pkg;
  timeunit 1ns; timeprecision 1ps;

  localparam int unsigned NUM_VREG = 32;
  localparam logic [6:0] OPC_VEC   = 7'b1010111;
  localparam logic [5:0] F6_GATHER = 6'b001100;

  typedef enum logic [1:0] {FORM_VV, FORM_VX, FORM_VI, FORM_BAD} form_e;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_COMMIT} state_e;

  typedef struct packed {
    form_e      form;
    logic       vm;
    logic [4:0] vd;
    logic [4:0] rs1;
    logic [4:0] vs2;
  } op_t;

  function automatic form_e form_of(input logic [2:0] f3);
    unique case (f3)
      3'b000:  return FORM_VV;
      3'b100:  return FORM_VX;
      3'b011:  return FORM_VI;
      default: return FORM_BAD;
    endcase
  endfunction
endpackage

// File: rtl/gather_decode.sv
module gather_decode import gather_pkg::*; #(
  parameter int unsigned NEL = 16,
  parameter int unsigned VLW = 5
) (
  input  logic [31:0]    insn_i,
  input  logic [1:0]     sew_i,
  input  logic [VLW-1:0] vl_i,
  output op_t            op_o,
  output logic           illegal_o,
  output logic [VLW-1:0] vlmax_o
);
  timeunit 1ns; timeprecision 1ps;

  always_comb begin
    op_o.form = form_of(insn_i[14:12]);
    op_o.vm   = insn_i[25];
    op_o.vd   = insn_i[11:7];
    op_o.rs1  = insn_i[19:15];
    op_o.vs2  = insn_i[24:20];
  end

  assign vlmax_o = VLW'(NEL >> sew_i);

  assign illegal_o = (insn_i[6:0] != OPC_VEC)
                  || (insn_i[31:26] != F6_GATHER)
                  || (op_o.form == FORM_BAD)
                  || (op_o.vd == op_o.vs2)
                  || (op_o.form == FORM_VV && op_o.vd == op_o.rs1)
                  || (!op_o.vm && op_o.vd == 5'd0)
                  || (vl_i > vlmax_o);
endmodule

// File: rtl/gather_vrf.sv
module gather_vrf #(
  parameter int unsigned NREG = 32,
  parameter int unsigned VLEN = 128,
  parameter int unsigned NRD  = 5,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [AW-1:0]   waddr_i,
  input  logic [VLEN-1:0] wdata_i,
  input  logic [AW-1:0]   raddr_i [NRD],
  output logic [VLEN-1:0] rdata_o [NRD]
);
  timeunit 1ns; timeprecision 1ps;

  logic [VLEN-1:0] mem_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NREG; k++) mem_q[k] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata_o[p] = mem_q[raddr_i[p]];
  end
endmodule

// File: rtl/gather_ctrl.sv
module gather_ctrl import gather_pkg::*; #(
  parameter int unsigned CW  = 4,
  parameter int unsigned VLW = 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           illegal_i,
  input  logic           vl_zero_i,
  input  logic [VLW-1:0] vlmax_i,
  output logic           busy_o,
  output logic           done_o,
  output logic           illegal_o,
  output logic           accept_o,
  output logic           load_o,
  output logic           run_o,
  output logic           commit_o,
  output logic [CW-1:0]  cnt_o
);
  timeunit 1ns; timeprecision 1ps;

  state_e         state_q;
  logic [VLW-1:0] vlmax_q;
  logic           last;

  assign accept_o = start_i && (state_q == ST_IDLE);
  assign load_o   = accept_o && !illegal_i && !vl_zero_i;
  assign run_o    = (state_q == ST_RUN);
  assign commit_o = (state_q == ST_COMMIT);
  assign busy_o   = (state_q != ST_IDLE);
  assign last     = (VLW'(cnt_o) == vlmax_q - VLW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_o     <= '0;
      vlmax_q   <= '0;
      done_o    <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      done_o    <= 1'b0;
      illegal_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (load_o) begin
            state_q <= ST_RUN;
            cnt_o   <= '0;
            vlmax_q <= vlmax_i;
          end else if (accept_o) begin
            // illegal or empty request: finish at once
            done_o    <= 1'b1;
            illegal_o <= illegal_i;
          end
        end
        ST_RUN: begin
          cnt_o <= cnt_o + CW'(1);
          if (last) state_q <= ST_COMMIT;
        end
        ST_COMMIT: begin
          state_q <= ST_IDLE;
          done_o  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R10
  run_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |-> (VLW'(cnt_o) < vlmax_q));

  // R10
  commit_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> (done_o && !busy_o));

  // R9
  illegal_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (done_o && !$past(commit_o)));
endmodule

// File: rtl/vgather_unit.sv
module vgather_unit import gather_pkg::*; #(
  parameter int unsigned VLEN = 128,
  parameter int unsigned XLEN = 64,
  localparam int unsigned NEL = VLEN / 8,
  localparam int unsigned CW  = $clog2(NEL),
  localparam int unsigned VLW = $clog2(NEL + 1),
  localparam int unsigned AW  = $clog2(NUM_VREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [31:0]     insn_i,
  input  logic [1:0]      sew_i,
  input  logic [VLW-1:0]  vl_i,
  input  logic [XLEN-1:0] scalar_i,
  input  logic            rf_we_i,
  input  logic [AW-1:0]   rf_waddr_i,
  input  logic [VLEN-1:0] rf_wdata_i,
  input  logic [AW-1:0]   rf_raddr_i,
  output logic [VLEN-1:0] rf_rdata_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            illegal_o
);
  timeunit 1ns; timeprecision 1ps;

  localparam int unsigned NRD = 5;
  localparam int unsigned P_SRC = 0, P_IDX = 1, P_MSK = 2, P_OLD = 3, P_EXT = 4;

  function automatic logic [63:0] elem_get(input logic [VLEN-1:0] v,
                                           input logic [CW-1:0] idx,
                                           input logic [1:0] sew);
    logic [VLEN-1:0] s;
    s = v >> (int'(idx) * (8 << sew));
    unique case (sew)
      2'd0:    return {56'd0, s[7:0]};
      2'd1:    return {48'd0, s[15:0]};
      2'd2:    return {32'd0, s[31:0]};
      default: return s[63:0];
    endcase
  endfunction

  function automatic logic [VLEN-1:0] elem_put(input logic [VLEN-1:0] v,
                                               input logic [CW-1:0] idx,
                                               input logic [1:0] sew,
                                               input logic [63:0] d);
    logic [63:0]     wm;
    logic [VLEN-1:0] m;
    int              pos;
    pos = int'(idx) * (8 << sew);
    unique case (sew)
      2'd0:    wm = 64'hFF;
      2'd1:    wm = 64'hFFFF;
      2'd2:    wm = 64'hFFFF_FFFF;
      default: wm = '1;
    endcase
    m = VLEN'(wm) << pos;
    return (v & ~m) | ((VLEN'(d) & VLEN'(wm)) << pos);
  endfunction

  op_t             dec_op, op_q;
  logic            dec_ill;
  logic [VLW-1:0]  dec_vlmax, vl_q, vlmax_cur;
  logic [1:0]      sew_q;
  logic [XLEN-1:0] scalar_q;
  logic [VLEN-1:0] buf_q, v0_sh;
  logic            accept, load, run, commit;
  logic [CW-1:0]   cnt;
  logic [AW-1:0]   rd_addr [NRD];
  logic [VLEN-1:0] rd_data [NRD];
  logic [63:0]     idx_val, src_elem, new_elem;
  logic            src_ok, in_body, active, elem_we;
  logic            rf_we;
  logic [AW-1:0]   rf_waddr;
  logic [VLEN-1:0] rf_wdata;

  gather_decode #(.NEL(NEL), .VLW(VLW)) i_decode (
    .insn_i    (insn_i),
    .sew_i     (sew_i),
    .vl_i      (vl_i),
    .op_o      (dec_op),
    .illegal_o (dec_ill),
    .vlmax_o   (dec_vlmax)
  );

  gather_ctrl #(.CW(CW), .VLW(VLW)) i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .illegal_i (dec_ill),
    .vl_zero_i (vl_i == '0),
    .vlmax_i   (dec_vlmax),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .illegal_o (illegal_o),
    .accept_o  (accept),
    .load_o    (load),
    .run_o     (run),
    .commit_o  (commit),
    .cnt_o     (cnt)
  );

  assign rd_addr[P_SRC] = op_q.vs2;
  assign rd_addr[P_IDX] = op_q.rs1;
  assign rd_addr[P_MSK] = '0;
  assign rd_addr[P_OLD] = dec_op.vd;
  assign rd_addr[P_EXT] = rf_raddr_i;
  assign rf_rdata_o     = rd_data[P_EXT];

  // commit only happens while busy, so the side port never competes
  assign rf_we    = commit || (rf_we_i && !busy_o);
  assign rf_waddr = commit ? op_q.vd : rf_waddr_i;
  assign rf_wdata = commit ? buf_q : rf_wdata_i;

  gather_vrf #(.NREG(NUM_VREG), .VLEN(VLEN), .NRD(NRD)) i_vrf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (rf_we),
    .waddr_i (rf_waddr),
    .wdata_i (rf_wdata),
    .raddr_i (rd_addr),
    .rdata_o (rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q     <= '0;
      sew_q    <= '0;
      vl_q     <= '0;
      scalar_q <= '0;
    end else if (accept) begin
      op_q     <= dec_op;
      sew_q    <= sew_i;
      vl_q     <= vl_i;
      scalar_q <= scalar_i;
    end
  end

  assign vlmax_cur = VLW'(NEL >> sew_q);

  always_comb begin
    unique case (op_q.form)
      FORM_VV: idx_val = elem_get(rd_data[P_IDX], cnt, sew_q);
      FORM_VX: idx_val = 64'(scalar_q);
      default: idx_val = {59'd0, op_q.rs1};
    endcase
  end

  assign src_ok   = idx_val < 64'(vlmax_cur);
  assign src_elem = elem_get(rd_data[P_SRC], idx_val[CW-1:0], sew_q);
  assign v0_sh    = rd_data[P_MSK] >> (int'(cnt) * (8 << sew_q));
  assign in_body  = VLW'(cnt) < vl_q;
  assign active   = op_q.vm || v0_sh[0];
  assign elem_we  = !in_body || active;
  assign new_elem = (in_body && src_ok) ? src_elem : 64'd0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
    end else if (load) begin
      buf_q <= rd_data[P_OLD];
    end else if (run && elem_we) begin
      buf_q <= elem_put(buf_q, cnt, sew_q, new_elem);
    end
  end

  // R11
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(op_q));

  // R8
  empty_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !dec_ill && vl_i == '0) |=> (done_o && !busy_o && !illegal_o));

  // R9
  illegal_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && dec_ill) |=> (!busy_o && !$past(load)));
endmodule

// File: tb/test_vgather_unit.sv
module test_vgather_unit;
  timeunit 1ns; timeprecision 1ps;

  localparam int VLEN = 128;

  typedef struct {
    bit              ill;
    int              due;
    logic [4:0]      vd;
    logic [VLEN-1:0] vec;
    string           tag;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [31:0]     insn = '0;
  logic [1:0]      sew = '0;
  logic [4:0]      vl = '0;
  logic [63:0]     scalar = '0;
  logic            rf_we = 1'b0;
  logic [4:0]      rf_waddr = '0;
  logic [VLEN-1:0] rf_wdata = '0;
  logic [4:0]      rf_raddr = '0;
  logic [VLEN-1:0] rf_rdata;
  logic            busy, done, illegal;

  int n_chk = 0, n_fail = 0, n_push = 0, n_pop = 0, cyc = 0;
  bit finished = 0;
  exp_t q[$];
  logic [VLEN-1:0] sh [32];

  vgather_unit i_vgather_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .insn_i(insn), .sew_i(sew),
    .vl_i(vl), .scalar_i(scalar), .rf_we_i(rf_we), .rf_waddr_i(rf_waddr),
    .rf_wdata_i(rf_wdata), .rf_raddr_i(rf_raddr), .rf_rdata_o(rf_rdata),
    .busy_o(busy), .done_o(done), .illegal_o(illegal)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag,
                     input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [2:0] f3, input logic vm,
                                     input logic [4:0] vd, input logic [4:0] rs1,
                                     input logic [4:0] vs2);
    return {6'b001100, vm, vs2, rs1, f3, vd, 7'b1010111};
  endfunction

  function automatic logic [63:0] getel(input logic [VLEN-1:0] v, input int i, input int w);
    logic [63:0] r = '0;
    for (int b = 0; b < w; b++) r[b] = v[i*w+b];
    return r;
  endfunction

  // independent reference of the requirements
  function automatic exp_t model(input logic [31:0] in, input logic [1:0] s,
                                 input int len, input logic [63:0] sc);
    exp_t e;
    int vlmax = 16 >> s;
    int w = 8 << s;
    logic [2:0] f3 = in[14:12];
    logic vm = in[25];
    logic [4:0] vd = in[11:7], rs1 = in[19:15], vs2 = in[24:20];
    logic [VLEN-1:0] r = sh[vd];
    bit ill;
    ill = (in[6:0] != 7'b1010111) || (in[31:26] != 6'b001100)
       || !(f3 == 3'b000 || f3 == 3'b100 || f3 == 3'b011)
       || (vd == vs2) || (f3 == 3'b000 && vd == rs1)
       || (!vm && vd == 5'd0) || (len > vlmax);
    if (!ill && len != 0) begin
      for (int i = 0; i < vlmax; i++) begin
        logic [63:0] idx, val;
        if (i >= len) val = '0;
        else begin
          if (!vm && !sh[0][i*w]) continue;
          if (f3 == 3'b000) idx = getel(sh[rs1], i, w);
          else if (f3 == 3'b100) idx = sc;
          else idx = {59'd0, rs1};
          val = (idx >= 64'(vlmax)) ? 64'd0 : getel(sh[vs2], int'(idx), w);
        end
        for (int b = 0; b < w; b++) r[i*w+b] = val[b];
      end
    end
    e.ill = ill;
    e.due = (ill || len == 0) ? 1 : vlmax + 2;
    e.vd = vd;
    e.vec = r;
    return e;
  endfunction

  task automatic load(input logic [4:0] a, input logic [VLEN-1:0] d);
    @(negedge clk);
    rf_we = 1'b1; rf_waddr = a; rf_wdata = d;
    sh[a] = d;
    @(negedge clk);
    rf_we = 1'b0;
  endtask

  // driver: pushes expected completion, optional second start mid-run
  task automatic issue(input logic [31:0] in, input logic [1:0] s, input int len,
                       input logic [63:0] sc, input string tag, input int intrude);
    exp_t e;
    e = model(in, s, len, sc);
    e.tag = tag;
    @(negedge clk);
    insn = in; sew = s; vl = 5'(len); scalar = sc; start = 1'b1;
    e.due = e.due + cyc;
    q.push_back(e);
    n_push++;
    @(negedge clk);
    start = 1'b0;
    if (intrude > 0) begin
      repeat (intrude) @(negedge clk);
      insn = mk(3'b100, 1'b1, 5'd12, 5'd0, 5'd2); sew = 2'd0; vl = 5'd2; scalar = 64'd1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    if (!e.ill && len != 0) sh[e.vd] = e.vec;
    wait (n_pop == n_push);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        if (q.size() == 0) begin
          chk(1'b0, "R11 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(illegal == e.ill, {e.tag, " R9 illegal flag"}, VLEN'(illegal), VLEN'(e.ill));
          chk(cyc == e.due, {e.tag, " R10 latency"}, VLEN'(cyc), VLEN'(e.due));
          rf_raddr = e.vd;
          #1;
          chk(rf_rdata === e.vec, {e.tag, " register contents"}, rf_rdata, e.vec);
          n_pop++;
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 32; k++) sh[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !illegal, "R10 reset idle", VLEN'({busy, done, illegal}), '0);
    chk(rf_rdata == '0, "R10 reset register", rf_rdata, '0);

    load(5'd0, 128'h5A3C_0F01_8421_F00F_AAAA_5555_1234_ABCD);
    load(5'd2, 128'hF0E1_D2C3_B4A5_9687_7869_5A4B_3C2D_1E0F);
    load(5'd3, 128'h000F_0310_FF01_070A_0B05_0E02_1104_0906);
    load(5'd4, 128'h0003_0101_0007_0000_0002_0008_0005_0001);
    for (int k = 5; k < 16; k++) load(5'(k), {4{32'hDEAD_0000 + 32'(k)}});

    issue(mk(3'b000, 1'b1, 5'd5, 5'd3, 5'd2), 2'd0, 16, 64'd0, "R2 R5 vv byte", 0);
    issue(mk(3'b000, 1'b0, 5'd6, 5'd4, 5'd2), 2'd1, 5, 64'd0, "R2 R6 R7 vv half masked", 0);
    issue(mk(3'b100, 1'b1, 5'd7, 5'd0, 5'd2), 2'd2, 3, 64'd2, "R3 R7 vx word", 0);
    issue(mk(3'b100, 1'b1, 5'd8, 5'd0, 5'd2), 2'd2, 4, 64'h1_0000_0001, "R3 R5 vx wide index", 0);
    issue(mk(3'b100, 1'b0, 5'd13, 5'd0, 5'd2), 2'd1, 8, 64'd6, "R3 R6 vx masked full", 0);
    issue(mk(3'b011, 1'b0, 5'd9, 5'd1, 5'd2), 2'd3, 1, 64'd0, "R4 R6 R7 vi dword", 0);
    issue(mk(3'b011, 1'b1, 5'd10, 5'd3, 5'd2), 2'd3, 2, 64'd0, "R4 R5 vi out of range", 0);
    issue(mk(3'b000, 1'b1, 5'd5, 5'd3, 5'd2), 2'd0, 0, 64'd0, "R8 zero length", 0);
    issue(mk(3'b000, 1'b1, 5'd2, 5'd3, 5'd2), 2'd0, 4, 64'd0, "R9 dest equals source", 0);
    issue(mk(3'b000, 1'b1, 5'd3, 5'd3, 5'd2), 2'd0, 4, 64'd0, "R9 dest equals index", 0);
    issue(mk(3'b100, 1'b0, 5'd0, 5'd0, 5'd2), 2'd0, 4, 64'd1, "R9 masked dest v0", 0);
    issue(mk(3'b100, 1'b1, 5'd11, 5'd0, 5'd2), 2'd1, 16, 64'd1, "R9 length over max", 0);
    issue(mk(3'b001, 1'b1, 5'd11, 5'd0, 5'd2), 2'd0, 4, 64'd1, "R1 bad form", 0);
    issue(mk(3'b000, 1'b1, 5'd11, 5'd3, 5'd2) ^ 32'h1, 2'd0, 4, 64'd0, "R1 bad opcode", 0);
    issue(mk(3'b000, 1'b1, 5'd11, 5'd3, 5'd2) ^ 32'h0400_0000, 2'd0, 4, 64'd0, "R1 bad funct6", 0);
    issue(mk(3'b000, 1'b1, 5'd11, 5'd3, 5'd2), 2'd0, 10, 64'd0, "R11 start while busy", 3);
    issue(mk(3'b100, 1'b1, 5'd0, 5'd0, 5'd2), 2'd0, 4, 64'd3, "R1 R9 unmasked into v0", 0);
    issue(mk(3'b000, 1'b0, 5'd14, 5'd3, 5'd2), 2'd0, 12, 64'd0, "R2 R6 R7 vv byte new mask", 0);

    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule